// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block holds the interrupt state of one processor across a 256-entry vector space. Three bit vectors of that width record which vectors are requested, which are in service, and which were last requested with level trigger. A request input latches a vector together with its trigger kind. The block forms a processor priority from a task-priority input and the highest in-service vector, and raises a level interrupt line when the highest requested vector belongs to a higher 16-vector class than that priority.

When the processor acknowledges, the block answers one cycle later. If a vector can be delivered, it returns that vector number and moves it from requested to in service. Otherwise it returns a programmable spurious vector and changes no state. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered and directed end-of-interrupt is off, the block pulses a broadcast output carrying the vector, so that upstream level sources can re-arm. Register access and destination routing are outside the block.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset nothing is requested or in service: `intrOut`, `ackValid` and `eoiBcastValid` are 0 and `procPri` is 0. A `reqValid` strobe records `reqVector` as requested from the next clock edge.
- R2: Among requested vectors, the one with the highest number is offered and acknowledged first.
- R3: The class of a vector is its upper 4 bits. `intrOut` is 1 only when the top requested vector's class is strictly greater than the class of `procPri`. A `procPri` of exactly 0 lets any requested vector through.
- R4: `procPri` equals `taskPri` when the class of `taskPri` is at least the class of the highest in-service vector, or when nothing is in service. Otherwise it equals that in-service vector with its low 4 bits cleared.
- R5: While `swEnable` is 0, `intrOut` stays 0 and every acknowledge returns the spurious vector.
- R6: An acknowledge while `intrOut` is 1 produces `ackValid` on the next cycle with `ackSpurious`=0 and `ackVector` equal to the top requested vector. That vector then leaves the requested set and enters the in-service set.
- R7: An acknowledge while `intrOut` is 0 produces `ackValid` with `ackSpurious`=1 and `ackVector`=`spurVector`, and leaves the requested and in-service sets unchanged.
- R8: `eoiReq` removes the highest-numbered in-service vector, which lowers `procPri` accordingly.
- R9: On such a removal, `eoiBcastValid` pulses for one cycle with `eoiBcastVector` set to the retired vector only if that vector's latest request was level (`reqLevel`=1) and `directedEoi` is 0.
- R10: `eoiReq` with nothing in service has no effect: no broadcast, and `procPri` and `intrOut` do not change.
- R11: A later edge request (`reqLevel`=0) of a vector clears its level mark, so retiring it gives no broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqVector | input | 8 | Requested vector number |
| reqLevel | input | 1 | 1 = level-triggered request, 0 = edge |
| taskPri | input | 8 | Task priority |
| swEnable | input | 1 | Software enable of delivery |
| directedEoi | input | 1 | 1 suppresses end-of-interrupt broadcasts |
| spurVector | input | 8 | Vector returned on a spurious acknowledge |
| ackReq | input | 1 | Processor acknowledge strobe |
| eoiReq | input | 1 | End-of-interrupt strobe |
| intrOut | output | 1 | Interrupt line to the processor |
| procPri | output | 8 | Current processor priority |
| ackValid | output | 1 | Acknowledge answer valid (one cycle after ackReq) |
| ackVector | output | 8 | Returned vector |
| ackSpurious | output | 1 | Returned vector is the spurious one |
| eoiBcastValid | output | 1 | End-of-interrupt broadcast pulse |
| eoiBcastVector | output | 8 | Vector carried by the broadcast |

## Verification
The hardest situation to reach is one where priority gating depends on both inputs to the processor priority at once: a vector in service whose class sits above, equal to or below the task priority, while another vector waits in a lower class. The bench gets there by acknowledging a high vector while a low one is still pending. It then sweeps `taskPri` through all 256 values with that state frozen, and again with nothing in service. A per-vector sweep also retires every one of the 256 vectors under both trigger kinds, with directed end-of-interrupt toggled, against a bit-level model kept in the bench.

// File: rtl/vpc_pkg.sv
`timescale 1ns/1ps
package vpc_pkg;
  localparam int VEC_BITS = 8;
  localparam int NUM_VEC  = 1 << VEC_BITS;

  typedef struct packed {
    logic                setReq;
    logic                reqLevel;
    logic [VEC_BITS-1:0] reqVec;
    logic                ackTake;
    logic [VEC_BITS-1:0] ackVec;
    logic                eoiTake;
    logic [VEC_BITS-1:0] eoiVec;
  } vpcStrobe_t;
endpackage

// File: rtl/vpc_prio_enc.sv
`timescale 1ns/1ps
module vpc_prio_enc #(
  parameter int WORD_BITS = 32,
  parameter int NUM_WORDS = 8,
  parameter int IDX_BITS  = 8
) (
  input  logic [NUM_WORDS*WORD_BITS-1:0] vecIn,
  output logic                           found,
  output logic [IDX_BITS-1:0]            topIdx
);
  localparam int OFF_BITS = $clog2(WORD_BITS);

  logic [NUM_WORDS-1:0] wordAny;
  logic [OFF_BITS-1:0]  wordMsb [NUM_WORDS];

  // per-word highest set bit
  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : gWord
      logic [OFF_BITS-1:0] msb;
      always_comb begin
        msb = '0;
        for (int b = 0; b < WORD_BITS; b++) begin
          if (vecIn[w*WORD_BITS + b]) msb = OFF_BITS'(b);
        end
      end
      assign wordAny[w] = |vecIn[w*WORD_BITS +: WORD_BITS];
      assign wordMsb[w] = msb;
    end
  endgenerate

  // highest non-empty word wins
  always_comb begin
    found  = 1'b0;
    topIdx = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (wordAny[i]) begin
        found  = 1'b1;
        topIdx = IDX_BITS'(i * WORD_BITS + int'(wordMsb[i]));
      end
    end
  end
endmodule

// File: rtl/vpc_datapath.sv
`timescale 1ns/1ps
module vpc_datapath
  import vpc_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int NUM_WORDS = NUM_VEC / WORD_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  vpcStrobe_t          str,
  output logic                irrFound,
  output logic [VEC_BITS-1:0] irrTop,
  output logic                isrFound,
  output logic [VEC_BITS-1:0] isrTop,
  output logic                isrTopLevel
);
  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic [NUM_VEC-1:0] irrNext, isrNext, tmrNext;
  logic [NUM_VEC-1:0] setMask, ackMask, eoiMask;

  always_comb begin
    setMask = str.setReq  ? (NUM_VEC'(1) << str.reqVec) : '0;
    ackMask = str.ackTake ? (NUM_VEC'(1) << str.ackVec) : '0;
    eoiMask = str.eoiTake ? (NUM_VEC'(1) << str.eoiVec) : '0;
    irrNext = (irr & ~ackMask) | setMask;
    isrNext = (isr & ~eoiMask) | ackMask;
    tmrNext = tmr;
    if (str.setReq) tmrNext[str.reqVec] = str.reqLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
    end else begin
      irr <= irrNext;
      isr <= isrNext;
      tmr <= tmrNext;
    end
  end

  vpc_prio_enc #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS), .IDX_BITS(VEC_BITS))
    uIrrEnc (.vecIn(irr), .found(irrFound), .topIdx(irrTop));
  vpc_prio_enc #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS), .IDX_BITS(VEC_BITS))
    uIsrEnc (.vecIn(isr), .found(isrFound), .topIdx(isrTop));

  assign isrTopLevel = tmr[isrTop];

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    str.ackTake |=> isr[$past(str.ackVec)]); // R6
  AST_ACK_CLEARS_IRR: assert property (@(posedge clk) disable iff (!rstN)
    (str.ackTake && !(str.setReq && str.reqVec == str.ackVec)) |=> !irr[$past(str.ackVec)]); // R6
  AST_REQ_SETS_IRR: assert property (@(posedge clk) disable iff (!rstN)
    str.setReq |=> irr[$past(str.reqVec)]); // R1
endmodule

// File: rtl/vpc_control.sv
`timescale 1ns/1ps
module vpc_control
  import vpc_pkg::*;
#(
  parameter int CLASS_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VEC_BITS-1:0] reqVector,
  input  logic                reqLevel,
  input  logic                ackReq,
  input  logic                eoiReq,
  input  logic [VEC_BITS-1:0] taskPri,
  input  logic                swEnable,
  input  logic                directedEoi,
  input  logic [VEC_BITS-1:0] spurVector,
  input  logic                irrFound,
  input  logic [VEC_BITS-1:0] irrTop,
  input  logic                isrFound,
  input  logic [VEC_BITS-1:0] isrTop,
  input  logic                isrTopLevel,
  output vpcStrobe_t          str,
  output logic                intrOut,
  output logic [VEC_BITS-1:0] procPri,
  output logic                ackValid,
  output logic [VEC_BITS-1:0] ackVector,
  output logic                ackSpurious,
  output logic                eoiBcastValid,
  output logic [VEC_BITS-1:0] eoiBcastVector
);
  localparam int SUB_BITS = VEC_BITS - CLASS_BITS;

  logic [CLASS_BITS-1:0] taskClass, isrClass, irrClass, pprClass;
  logic deliverable;

  assign taskClass = taskPri[VEC_BITS-1 -: CLASS_BITS];
  assign isrClass  = isrTop[VEC_BITS-1 -: CLASS_BITS];
  assign irrClass  = irrTop[VEC_BITS-1 -: CLASS_BITS];

  always_comb begin
    if (!isrFound || taskClass >= isrClass) procPri = taskPri;
    else                                    procPri = {isrClass, {SUB_BITS{1'b0}}};
  end
  assign pprClass = procPri[VEC_BITS-1 -: CLASS_BITS];

  assign deliverable = swEnable && irrFound &&
                       ((procPri == '0) || (irrClass > pprClass));
  assign intrOut = deliverable;

  always_comb begin
    str.setReq   = reqValid;
    str.reqLevel = reqLevel;
    str.reqVec   = reqVector;
    str.ackTake  = ackReq && deliverable;
    str.ackVec   = irrTop;
    str.eoiTake  = eoiReq && isrFound;
    str.eoiVec   = isrTop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid       <= 1'b0;
      ackVector      <= '0;
      ackSpurious    <= 1'b0;
      eoiBcastValid  <= 1'b0;
      eoiBcastVector <= '0;
    end else begin
      ackValid      <= ackReq;
      ackSpurious   <= ackReq && !deliverable;
      if (ackReq) ackVector <= deliverable ? irrTop : spurVector;
      eoiBcastValid <= str.eoiTake && isrTopLevel && !directedEoi;
      if (str.eoiTake) eoiBcastVector <= isrTop;
    end
  end

  AST_ACK_ONE_LATER: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(ackReq)); // R6
  AST_SPUR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !$past(swEnable)) |-> ackSpurious); // R5
  AST_BCAST_NOT_DIRECTED: assert property (@(posedge clk) disable iff (!rstN)
    eoiBcastValid |-> (!$past(directedEoi) && $past(isrTopLevel))); // R9
  AST_EOI_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (eoiReq && !isrFound) |=> !eoiBcastValid); // R10
endmodule

// File: rtl/vec_prio_ctrl.sv
`timescale 1ns/1ps
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int WORD_BITS  = 32,
  parameter int CLASS_BITS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [7:0] reqVector,
  input  logic       reqLevel,
  input  logic [7:0] taskPri,
  input  logic       swEnable,
  input  logic       directedEoi,
  input  logic [7:0] spurVector,
  input  logic       ackReq,
  input  logic       eoiReq,
  output logic       intrOut,
  output logic [7:0] procPri,
  output logic       ackValid,
  output logic [7:0] ackVector,
  output logic       ackSpurious,
  output logic       eoiBcastValid,
  output logic [7:0] eoiBcastVector
);
  localparam int NUM_WORDS = NUM_VEC / WORD_BITS;

  vpcStrobe_t          str;
  logic                irrFound, isrFound, isrTopLevel;
  logic [VEC_BITS-1:0] irrTop, isrTop;

  vpc_control #(.CLASS_BITS(CLASS_BITS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVector(reqVector), .reqLevel(reqLevel),
    .ackReq(ackReq), .eoiReq(eoiReq), .taskPri(taskPri),
    .swEnable(swEnable), .directedEoi(directedEoi), .spurVector(spurVector),
    .irrFound(irrFound), .irrTop(irrTop), .isrFound(isrFound),
    .isrTop(isrTop), .isrTopLevel(isrTopLevel),
    .str(str), .intrOut(intrOut), .procPri(procPri),
    .ackValid(ackValid), .ackVector(ackVector), .ackSpurious(ackSpurious),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVector(eoiBcastVector)
  );

  vpc_datapath #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS)) uData (
    .clk(clk), .rstN(rstN), .str(str),
    .irrFound(irrFound), .irrTop(irrTop),
    .isrFound(isrFound), .isrTop(isrTop), .isrTopLevel(isrTopLevel)
  );
endmodule

// File: tb/sim_vec_prio_ctrl.sv
`timescale 1ns/1ps
module sim_vec_prio_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqLevel = 0, swEnable = 1, directedEoi = 0, ackReq = 0, eoiReq = 0;
  logic [7:0] reqVector = 0, taskPri = 0, spurVector = 8'hFF;
  logic intrOut, ackValid, ackSpurious, eoiBcastValid;
  logic [7:0] procPri, ackVector, eoiBcastVector;

  int checks = 0;
  int errors = 0;
  bit [255:0] mIrr = '0, mIsr = '0, mTmr = '0;

  always #2.5 clk = ~clk;

  vec_prio_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .reqLevel(reqLevel), .taskPri(taskPri), .swEnable(swEnable),
    .directedEoi(directedEoi), .spurVector(spurVector), .ackReq(ackReq),
    .eoiReq(eoiReq), .intrOut(intrOut), .procPri(procPri), .ackValid(ackValid),
    .ackVector(ackVector), .ackSpurious(ackSpurious),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVector(eoiBcastVector)
  );

  function automatic int topOf(bit [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int modelPpr();
    int s = topOf(mIsr);
    int sc = (s < 0) ? 0 : (s / 16);
    if ((int'(taskPri) / 16) >= sc) return int'(taskPri);
    return sc * 16;
  endfunction

  function automatic int modelDeliv();
    int r = topOf(mIrr);
    int p = modelPpr();
    if (!swEnable || r < 0) return 0;
    if (p == 0) return 1;
    return ((r / 16) > (p / 16)) ? 1 : 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkLevels(string tag);
    chk(tag, "intrOut", int'(intrOut), modelDeliv());
    chk(tag, "procPri", int'(procPri), modelPpr());
  endtask

  task automatic doReq(int v, bit lvl);
    reqVector = 8'(v); reqLevel = lvl; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    mIrr[v] = 1'b1; mTmr[v] = lvl;
  endtask

  task automatic doAck(string tag);
    int d = modelDeliv();
    int r = topOf(mIrr);
    ackReq = 1;
    @(negedge clk);
    ackReq = 0;
    chk(tag, "ackValid", int'(ackValid), 1);
    if (d != 0) begin
      chk(tag, "ackVector", int'(ackVector), r);
      chk(tag, "ackSpurious", int'(ackSpurious), 0);
      mIrr[r] = 1'b0; mIsr[r] = 1'b1;
    end else begin
      chk(tag, "ackVector", int'(ackVector), int'(spurVector));
      chk(tag, "ackSpurious", int'(ackSpurious), 1);
    end
  endtask

  task automatic doEoi(string tag);
    int s = topOf(mIsr);
    int expB = 0;
    eoiReq = 1;
    @(negedge clk);
    eoiReq = 0;
    if (s >= 0) begin
      expB = (mTmr[s] && !directedEoi) ? 1 : 0;
      mIsr[s] = 1'b0;
    end
    chk(tag, "eoiBcastValid", int'(eoiBcastValid), expB);
    if (expB != 0) chk(tag, "eoiBcastVector", int'(eoiBcastVector), s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "intrOut", int'(intrOut), 0);
    chk("R1", "procPri", int'(procPri), 0);
    chk("R1", "ackValid", int'(ackValid), 0);
    chk("R1", "eoiBcastValid", int'(eoiBcastValid), 0);

    // sweep of all vectors under both trigger kinds
    for (int v = 0; v < 256; v++) begin
      doReq(v, 0);      checkLevels("R1");
      doAck("R6");      checkLevels("R4");
      doEoi("R9");      checkLevels("R8");
      doReq(v, 1);      checkLevels("R3");
      doAck("R6");
      directedEoi = (v % 3 == 0);
      doEoi("R9");      checkLevels("R8");
      directedEoi = 0;
    end

    // task priority sweep, nothing in service
    doReq(8'h20, 0); doReq(8'hA7, 0);
    for (int tp = 0; tp < 256; tp++) begin
      taskPri = 8'(tp); #1; checkLevels("R3");
      @(negedge clk);
    end
    taskPri = 0; @(negedge clk);
    doAck("R2"); checkLevels("R4");   // A7 in service, 20 waits
    for (int tp = 0; tp < 256; tp++) begin
      taskPri = 8'(tp); #1; checkLevels("R4");
      @(negedge clk);
    end
    taskPri = 0; @(negedge clk);
    doAck("R7"); checkLevels("R7");   // 20 blocked by class A
    doEoi("R8"); checkLevels("R8");
    doAck("R6"); checkLevels("R6");
    doEoi("R8");

    // nested classes
    doReq(8'h35, 0); doReq(8'h72, 0); doReq(8'h51, 0);
    doAck("R2"); checkLevels("R2");   // 72
    doAck("R7"); checkLevels("R7");
    doReq(8'h90, 1); checkLevels("R3");
    doAck("R2"); checkLevels("R4");   // 90 nested over 72
    doEoi("R9"); checkLevels("R8");   // retires 90 with broadcast
    doEoi("R8"); checkLevels("R8");   // retires 72
    doAck("R2"); doAck("R2"); checkLevels("R4");
    doEoi("R8"); doEoi("R8"); checkLevels("R8");

    // raised task priority
    taskPri = 8'h80; @(negedge clk);
    doReq(8'h85, 0); checkLevels("R3");
    doAck("R7"); checkLevels("R7");
    doReq(8'h91, 0); checkLevels("R3");
    doAck("R6"); doEoi("R8");
    taskPri = 8'h05; @(negedge clk); checkLevels("R3");
    doAck("R6"); doEoi("R8");
    doReq(8'h03, 0); checkLevels("R3");
    spurVector = 8'h3C;
    doAck("R7"); checkLevels("R7");
    taskPri = 0; @(negedge clk);
    doAck("R6"); doEoi("R8");

    // software enable
    doReq(8'h60, 0);
    swEnable = 0; #1; checkLevels("R5");
    @(negedge clk);
    doAck("R5"); checkLevels("R5");
    swEnable = 1; #1; checkLevels("R5");
    @(negedge clk);
    doAck("R6"); doEoi("R8"); checkLevels("R8");

    // end of interrupt with empty in-service set
    doEoi("R10"); checkLevels("R10");
    doReq(8'h44, 0); checkLevels("R10");
    doEoi("R10"); checkLevels("R10");
    doAck("R6"); doEoi("R8");

    // level mark cleared by a later edge request
    doReq(8'h40, 1); doReq(8'h40, 0);
    doAck("R11"); doEoi("R11"); checkLevels("R11");
    doReq(8'h41, 0); doReq(8'h41, 1);
    doAck("R11"); doEoi("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule